// File: doc/BRIEF.md
# Four-Port Cell Bus PHY Slave

This block is the physical-layer side of a 16-bit, multi-port cell bus that serves four line ports. An upstream cell engine polls the ports by putting a 5-bit address on the bus of each direction. Each port answers with a one-bit cell-available flag. The engine then selects one port and moves a whole 53-byte cell as 27 sixteen-bit words. The first word is flagged by start-of-cell, and every word carries one odd-parity bit. The low byte of the last word is padding.

On the transmit path, the block checks the parity of each accepted word and hands every word to an external per-port cell store through a write-beat interface. This interface carries the port, the word index, a last-word marker and an abort marker for partial cells. For each started cell, the block also stretches the start event into a fixed active-low LED pulse, counted on a separate free-running oscillator clock. On the receive path, the block reads words from an external per-port cell store and presents them with start-of-cell and generated parity. When the last word is presented, it pops that cell. The per-port addresses and the parity-interrupt enable come in as static configuration inputs.

Top module: `cbq_phy_top`

## Requirements
- R1: A cell-available output reflects, one clock after the address is presented, the status bit of the port whose configured 5-bit address (field p at bits [5p+4:5p] of `port_addr_cfg`) equals the bus address. For transmit the status bit is room in the store (`txb_room`); for receive it is a ready cell (`rxb_ready`).
- R2: When no configured port address matches the bus address, the cell-available output is high impedance, one clock later.
- R3: A transmit word is accepted only on a rising edge where `tx_en_n` is 0. Accepted word k of a cell (k = 0..26) appears one clock later as a beat with `txw_valid`=1, `txw_idx`=k, `txw_port` = the port number and `txw_data` = the word. `txw_last`=1 is set on index 26.
- R4: The transmit (and receive) port is the one whose address was on the bus at the last rising edge with enable high while no cell was in progress. Address changes during a cell, including enable-high pauses, do not change the port.
- R5: With `par_irq_en`=1, an accepted transmit word whose 17 bits (data plus parity) hold an even number of ones sets the sticky bit `tx_par_irq[port]`. The word is still delivered, and the cell still completes with 27 beats.
- R6: With `par_irq_en`=0, a parity error leaves `tx_par_irq` unchanged, and the cell is delivered in full.
- R7: A transmit start-of-cell while a cell is in progress gives, in the same beat cycle, `txw_abort`=1 with `txw_abort_port` = that port, and sets the sticky bit `tx_runt[port]`. It then restarts the cell on the same port at index 0.
- R8: On receive, once a ready port is selected, each rising edge with `rx_en_n`=0 loads the next word (index 0..26, from `rxr_data` at `rxr_port`/`rxr_idx`) onto `rx_data`. `rx_soc`=1 is set with word 0 only. `rx_data` holds while `rx_en_n`=1. `rxr_pop`=1 with `rxr_pop_port` is set in the cycle word 26 is presented.
- R9: `rx_par` makes the 17 bits {`rx_par`,`rx_data`} hold an odd number of ones at all times.
- R10: Each transmit start-of-cell drives `tx_led_n[port]` low for 223 `osc_clk` cycles. A new start-of-cell during the pulse restarts the count, so the low time becomes the gap plus 223.
- R11: Transmit words with `tx_en_n`=0 and no cell in progress are ignored unless they carry start-of-cell with a port selected. Such words produce no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Free-running oscillator clock for LED timing |
| port_addr_cfg | input | NPORT*AW | Configured bus address of each port |
| par_irq_en | input | 1 | Enables parity-error status bits |
| tx_addr | input | AW | Transmit poll/select address |
| tx_en_n | input | 1 | Transmit enable, active low |
| tx_soc | input | 1 | Transmit start-of-cell |
| tx_data | input | DW | Transmit word |
| tx_par | input | 1 | Transmit odd parity |
| tx_clav | output | 1 | Transmit cell-available, tri-state |
| txb_room | input | NPORT | Per-port room-for-a-cell status |
| txw_valid | output | 1 | Write beat valid |
| txw_port | output | PW | Write beat port |
| txw_idx | output | IW | Write beat word index |
| txw_data | output | DW | Write beat data |
| txw_last | output | 1 | Beat is the final word of a cell |
| txw_abort | output | 1 | Discard partial cell |
| txw_abort_port | output | PW | Port of discarded cell |
| tx_par_irq | output | NPORT | Sticky parity-error bits |
| tx_runt | output | NPORT | Sticky short-cell bits |
| tx_led_n | output | NPORT | Active-low activity LED pulses |
| rx_addr | input | AW | Receive poll/select address |
| rx_en_n | input | 1 | Receive enable, active low |
| rx_soc | output | 1 | Receive start-of-cell |
| rx_data | output | DW | Receive word |
| rx_par | output | 1 | Receive odd parity |
| rx_clav | output | 1 | Receive cell-available, tri-state |
| rxb_ready | input | NPORT | Per-port full cell ready |
| rxr_port | output | PW | Store read port |
| rxr_idx | output | IW | Store read word index |
| rxr_data | input | DW | Store read data, same cycle |
| rxr_pop | output | 1 | Remove the cell just sent |
| rxr_pop_port | output | PW | Port of popped cell |

## Verification
The bench polls with an unmatched address while every status bit is 1. On a pulled-down net, a design that drove the line instead of floating it would read 1. It pauses a cell and moves the address during the pause; a design that re-decoded the address there would write the remaining beats to the wrong port. It injects a parity error with the enable on and off, checking that the cell is never shortened. It cuts a cell short with a fresh start-of-cell, where a design that appended instead of restarting would lose the abort or overrun index 26. Finally it measures the LED low time in oscillator cycles for a single pulse and for a restarted one, which exposes wrong lengths and lost retriggers.

// File: rtl/cbq_pkg.sv
package cbq_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_ARMED = 2'd1,
    SEL_XFER  = 2'd2
  } sel_state_e;
endpackage

// File: rtl/cbq_addr_match.sv
module cbq_addr_match #(
  parameter int NPORT = 4,
  parameter int AW    = 5,
  parameter int PW    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic [NPORT*AW-1:0] cfg,
  input  logic [NPORT-1:0]    stat,
  output logic                hit,
  output logic [PW-1:0]       hit_port,
  output logic                clav_q,
  output logic                clav_oe
);
  // lowest port index wins if two ports share an address
  always_comb begin
    hit      = 1'b0;
    hit_port = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (cfg[p*AW +: AW] == addr) begin
        hit      = 1'b1;
        hit_port = PW'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clav_q  <= 1'b0;
      clav_oe <= 1'b0;
    end else begin
      clav_oe <= hit;
      clav_q  <= hit & stat[hit_port];
    end
  end

  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !clav_oe |-> !clav_q) else $error("clav driven high while floating"); // R2
endmodule

// File: rtl/cbq_tx_ingest.sv
module cbq_tx_ingest
  import cbq_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int DW    = 16,
  parameter int WORDS = 27,
  parameter int PW    = 2,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_irq_en,
  input  logic             tx_en_n,
  input  logic             tx_soc,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_par,
  input  logic             hit,
  input  logic [PW-1:0]    hit_port,
  output logic             txw_valid,
  output logic [PW-1:0]    txw_port,
  output logic [IW-1:0]    txw_idx,
  output logic [DW-1:0]    txw_data,
  output logic             txw_last,
  output logic             txw_abort,
  output logic [PW-1:0]    txw_abort_port,
  output logic [NPORT-1:0] tx_par_irq,
  output logic [NPORT-1:0] tx_runt,
  output logic [NPORT-1:0] soc_tog
);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  sel_state_e    st;
  logic [PW-1:0] sel_p;
  logic [PW-1:0] cur;
  logic [IW-1:0] nidx;
  logic          word_ok;
  logic [PW-1:0] start_p;

  assign word_ok = ^{tx_par, tx_data};
  assign start_p = (st == SEL_XFER) ? cur : sel_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= SEL_IDLE;
      sel_p          <= '0;
      cur            <= '0;
      nidx           <= '0;
      txw_valid      <= 1'b0;
      txw_port       <= '0;
      txw_idx        <= '0;
      txw_data       <= '0;
      txw_last       <= 1'b0;
      txw_abort      <= 1'b0;
      txw_abort_port <= '0;
      tx_par_irq     <= '0;
      tx_runt        <= '0;
      soc_tog        <= '0;
    end else begin
      txw_valid <= 1'b0;
      txw_last  <= 1'b0;
      txw_abort <= 1'b0;
      if (tx_en_n) begin
        if (st != SEL_XFER) begin
          st    <= hit ? SEL_ARMED : SEL_IDLE;
          sel_p <= hit_port;
        end
      end else if (tx_soc && st != SEL_IDLE) begin
        if (st == SEL_XFER) begin
          txw_abort      <= 1'b1;
          txw_abort_port <= cur;
          tx_runt[cur]   <= 1'b1;
        end
        st                <= SEL_XFER;
        cur               <= start_p;
        nidx              <= IW'(1);
        txw_valid         <= 1'b1;
        txw_port          <= start_p;
        txw_idx           <= '0;
        txw_data          <= tx_data;
        soc_tog[start_p]  <= ~soc_tog[start_p];
        if (!word_ok && par_irq_en) tx_par_irq[start_p] <= 1'b1;
      end else if (st == SEL_XFER && !tx_soc) begin
        txw_valid <= 1'b1;
        txw_port  <= cur;
        txw_idx   <= nidx;
        txw_data  <= tx_data;
        nidx      <= nidx + IW'(1);
        if (!word_ok && par_irq_en) tx_par_irq[cur] <= 1'b1;
        if (nidx == LAST_IDX) begin
          txw_last <= 1'b1;
          st       <= SEL_IDLE;
        end
      end
    end
  end

  AST_BEAT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    txw_valid |-> $past(!tx_en_n)) else $error("beat without enable"); // R3
  AST_FIRST_BEAT_SOC: assert property (@(posedge clk) disable iff (rst)
    (txw_valid && txw_idx == '0) |-> $past(tx_soc)) else $error("index 0 without soc"); // R7
  AST_LAST_AT_END: assert property (@(posedge clk) disable iff (rst)
    txw_last |-> (txw_valid && txw_idx == LAST_IDX)) else $error("last misplaced"); // R3
  AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    txw_abort |-> (txw_valid && txw_idx == '0 && txw_port == txw_abort_port)) else $error("abort without restart"); // R7
endmodule

// File: rtl/cbq_rx_egress.sv
module cbq_rx_egress
  import cbq_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int DW    = 16,
  parameter int WORDS = 27,
  parameter int PW    = 2,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en_n,
  input  logic             hit,
  input  logic [PW-1:0]    hit_port,
  input  logic [NPORT-1:0] rxb_ready,
  input  logic [DW-1:0]    rxr_data,
  output logic [PW-1:0]    rxr_port,
  output logic [IW-1:0]    rxr_idx,
  output logic             rxr_pop,
  output logic [PW-1:0]    rxr_pop_port,
  output logic             rx_soc,
  output logic [DW-1:0]    rx_data,
  output logic             rx_par
);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  sel_state_e    st;
  logic [PW-1:0] sel_p;
  logic [PW-1:0] cur;
  logic [IW-1:0] nidx;

  assign rxr_port = (st == SEL_XFER) ? cur : sel_p;
  assign rxr_idx  = (st == SEL_XFER) ? nidx : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SEL_IDLE;
      sel_p        <= '0;
      cur          <= '0;
      nidx         <= '0;
      rxr_pop      <= 1'b0;
      rxr_pop_port <= '0;
      rx_soc       <= 1'b0;
      rx_data      <= '0;
      rx_par       <= 1'b1;
    end else begin
      rxr_pop <= 1'b0;
      if (rx_en_n) begin
        if (st != SEL_XFER) begin
          st    <= hit ? SEL_ARMED : SEL_IDLE;
          sel_p <= hit_port;
        end
      end else if (st == SEL_ARMED && rxb_ready[sel_p]) begin
        st      <= SEL_XFER;
        cur     <= sel_p;
        nidx    <= IW'(1);
        rx_soc  <= 1'b1;
        rx_data <= rxr_data;
        rx_par  <= ~^rxr_data;
      end else if (st == SEL_XFER) begin
        rx_soc  <= 1'b0;
        rx_data <= rxr_data;
        rx_par  <= ~^rxr_data;
        nidx    <= nidx + IW'(1);
        if (nidx == LAST_IDX) begin
          rxr_pop      <= 1'b1;
          rxr_pop_port <= cur;
          st           <= SEL_IDLE;
        end
      end
    end
  end

  AST_RX_ODD: assert property (@(posedge clk) disable iff (rst)
    ^{rx_par, rx_data}) else $error("rx parity not odd"); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(rx_en_n) |-> ($stable(rx_data) && $stable(rx_soc))) else $error("rx moved without enable"); // R8
  AST_RX_POP_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    rxr_pop |-> $past(!rx_en_n)) else $error("pop without enable"); // R8
endmodule

// File: rtl/cbq_led_stretch.sv
module cbq_led_stretch #(
  parameter int LED_CYC = 223,
  parameter int CW      = 8
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic soc_tog,
  output logic led_n
);
  localparam logic [CW-1:0] LOAD = CW'(LED_CYC);

  logic [1:0]    rst_s;
  logic          orst;
  logic [2:0]    tsync;
  logic          evt;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign orst = rst_s[1];
  assign evt  = tsync[2] ^ tsync[1];

  always_comb begin
    if (evt)             cnt_nx = LOAD;
    else if (cnt != '0)  cnt_nx = cnt - CW'(1);
    else                 cnt_nx = '0;
  end

  always_ff @(posedge osc_clk) begin
    rst_s <= {rst_s[0], rst};
  end

  always_ff @(posedge osc_clk) begin
    if (orst) begin
      tsync <= '0;
      cnt   <= '0;
      led_n <= 1'b1;
    end else begin
      tsync <= {tsync[1:0], soc_tog};
      cnt   <= cnt_nx;
      led_n <= (cnt_nx == '0);
    end
  end

  AST_LED_FOLLOWS_COUNT: assert property (@(posedge osc_clk) disable iff (orst)
    $past(evt) |-> !led_n) else $error("led not low after event"); // R10
endmodule

// File: rtl/cbq_phy_top.sv
module cbq_phy_top #(
  parameter int NPORT   = 4,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int WORDS   = 27,
  parameter int LED_CYC = 223,
  parameter int PW      = $clog2(NPORT),
  parameter int IW      = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_clk,
  input  logic [NPORT*AW-1:0] port_addr_cfg,
  input  logic                par_irq_en,
  input  logic [AW-1:0]       tx_addr,
  input  logic                tx_en_n,
  input  logic                tx_soc,
  input  logic [DW-1:0]       tx_data,
  input  logic                tx_par,
  output logic                tx_clav,
  input  logic [NPORT-1:0]    txb_room,
  output logic                txw_valid,
  output logic [PW-1:0]       txw_port,
  output logic [IW-1:0]       txw_idx,
  output logic [DW-1:0]       txw_data,
  output logic                txw_last,
  output logic                txw_abort,
  output logic [PW-1:0]       txw_abort_port,
  output logic [NPORT-1:0]    tx_par_irq,
  output logic [NPORT-1:0]    tx_runt,
  output logic [NPORT-1:0]    tx_led_n,
  input  logic [AW-1:0]       rx_addr,
  input  logic                rx_en_n,
  output logic                rx_soc,
  output logic [DW-1:0]       rx_data,
  output logic                rx_par,
  output logic                rx_clav,
  input  logic [NPORT-1:0]    rxb_ready,
  output logic [PW-1:0]       rxr_port,
  output logic [IW-1:0]       rxr_idx,
  input  logic [DW-1:0]       rxr_data,
  output logic                rxr_pop,
  output logic [PW-1:0]       rxr_pop_port
);
  localparam int CW = $clog2(LED_CYC + 1);

  logic          tx_hit, rx_hit;
  logic [PW-1:0] tx_hit_p, rx_hit_p;
  logic          tx_cq, tx_oe, rx_cq, rx_oe;
  logic [NPORT-1:0] soc_tog;

  cbq_addr_match #(.NPORT(NPORT), .AW(AW), .PW(PW)) u_tx_match (
    .clk(clk), .rst(rst), .addr(tx_addr), .cfg(port_addr_cfg), .stat(txb_room),
    .hit(tx_hit), .hit_port(tx_hit_p), .clav_q(tx_cq), .clav_oe(tx_oe)
  );

  cbq_addr_match #(.NPORT(NPORT), .AW(AW), .PW(PW)) u_rx_match (
    .clk(clk), .rst(rst), .addr(rx_addr), .cfg(port_addr_cfg), .stat(rxb_ready),
    .hit(rx_hit), .hit_port(rx_hit_p), .clav_q(rx_cq), .clav_oe(rx_oe)
  );

  assign tx_clav = tx_oe ? tx_cq : 1'bz;
  assign rx_clav = rx_oe ? rx_cq : 1'bz;

  cbq_tx_ingest #(.NPORT(NPORT), .DW(DW), .WORDS(WORDS), .PW(PW), .IW(IW)) u_tx (
    .clk(clk), .rst(rst), .par_irq_en(par_irq_en),
    .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par),
    .hit(tx_hit), .hit_port(tx_hit_p),
    .txw_valid(txw_valid), .txw_port(txw_port), .txw_idx(txw_idx),
    .txw_data(txw_data), .txw_last(txw_last), .txw_abort(txw_abort),
    .txw_abort_port(txw_abort_port), .tx_par_irq(tx_par_irq),
    .tx_runt(tx_runt), .soc_tog(soc_tog)
  );

  cbq_rx_egress #(.NPORT(NPORT), .DW(DW), .WORDS(WORDS), .PW(PW), .IW(IW)) u_rx (
    .clk(clk), .rst(rst), .rx_en_n(rx_en_n), .hit(rx_hit), .hit_port(rx_hit_p),
    .rxb_ready(rxb_ready), .rxr_data(rxr_data), .rxr_port(rxr_port),
    .rxr_idx(rxr_idx), .rxr_pop(rxr_pop), .rxr_pop_port(rxr_pop_port),
    .rx_soc(rx_soc), .rx_data(rx_data), .rx_par(rx_par)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_led
    cbq_led_stretch #(.LED_CYC(LED_CYC), .CW(CW)) u_led (
      .osc_clk(osc_clk), .rst(rst), .soc_tog(soc_tog[p]), .led_n(tx_led_n[p])
    );
  end
endmodule

// File: tb/sim_cbq_phy_top.sv
module sim_cbq_phy_top;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 14;

  logic clk = 0, osc_clk = 0, rst = 1;
  logic [19:0] port_addr_cfg = {5'h07, 5'h1E, 5'h11, 5'h03};
  logic par_irq_en = 0;
  logic [4:0] tx_addr = 5'h1F, rx_addr = 5'h1F;
  logic tx_en_n = 1, tx_soc = 0, tx_par = 1, rx_en_n = 1;
  logic [15:0] tx_data = 0;
  logic [3:0] txb_room = 0, rxb_ready = 0;
  tri0 tx_clav, rx_clav;
  logic txw_valid, txw_last, txw_abort, rx_soc, rx_par, rxr_pop;
  logic [1:0] txw_port, txw_abort_port, rxr_port, rxr_pop_port;
  logic [4:0] txw_idx, rxr_idx;
  logic [15:0] txw_data, rx_data, rxr_data;
  logic [3:0] tx_par_irq, tx_runt, tx_led_n;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(OSC_PERIOD/2) osc_clk = ~osc_clk;

  cbq_phy_top u0 (.*);

  function automatic logic [15:0] twd(input int p, input int i);
    return 16'(16'h1000 * (p + 1) + i * 16'h0107 + 16'h0050);
  endfunction
  function automatic logic [15:0] rwd(input int p, input int i);
    return 16'(16'hC003 ^ (p << 10) ^ (i * 16'h0123));
  endfunction
  function automatic logic [4:0] paddr(input int p);
    return port_addr_cfg[p*5 +: 5];
  endfunction

  assign rxr_data = rwd(int'(rxr_port), int'(rxr_idx));

  // transmit-side cell store model
  logic [15:0] cap_data [27];
  int cap_n, cap_last, cap_abort, cap_badport;
  int cap_port;
  always @(posedge clk) begin
    if (!rst && txw_valid) begin
      cap_n++;
      cap_data[txw_idx] = txw_data;
      if (int'(txw_port) != cap_port) cap_badport++;
      if (txw_last) cap_last++;
    end
    if (!rst && txw_abort) cap_abort++;
  end

  int led_low [4];
  always @(negedge osc_clk)
    for (int p = 0; p < 4; p++) if (!tx_led_n[p]) led_low[p]++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_cap(input int p);
    cap_n = 0; cap_last = 0; cap_abort = 0; cap_badport = 0; cap_port = p;
    for (int i = 0; i < 27; i++) cap_data[i] = 16'h0;
  endtask

  function automatic int data_miss(input int p);
    int m = 0;
    for (int i = 0; i < 27; i++) if (cap_data[i] !== twd(p, i)) m++;
    return m;
  endfunction

  task automatic tx_cell(input int p, input int nw, input int bad_at, input int pause_at);
    @(negedge clk); tx_addr = paddr(p); tx_en_n = 1; tx_soc = 0;
    for (int i = 0; i < nw; i++) begin
      if (i == pause_at) begin
        @(negedge clk); tx_en_n = 1; tx_addr = paddr((p + 1) % 4);
        @(negedge clk);
      end
      @(negedge clk);
      tx_en_n = 0; tx_soc = (i == 0); tx_data = twd(p, i);
      tx_par = (~^twd(p, i)) ^ (i == bad_at);
    end
    @(negedge clk); tx_en_n = 1; tx_soc = 0; tx_addr = 5'h1F;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(tx_clav === 1'b0 && rx_clav === 1'b0, "R2 reset clav floats", int'(tx_clav), 0);
    chk(tx_led_n === 4'hF, "R10 reset led off", int'(tx_led_n), 15);
    chk(tx_par_irq === 0 && tx_runt === 0, "R5 reset status clear", int'({tx_par_irq, tx_runt}), 0);
    chk(txw_valid === 1'b0 && rxr_pop === 1'b0, "R3 reset no beat", int'(txw_valid), 0);
  endtask

  task automatic t_poll;
    txb_room = 4'b0101; rxb_ready = 4'b0010;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); tx_addr = paddr(p); rx_addr = paddr(p);
      @(negedge clk);
      chk(tx_clav === txb_room[p], "R1 tx clav per port", int'(tx_clav), int'(txb_room[p]));
      chk(rx_clav === rxb_ready[p], "R1 rx clav per port", int'(rx_clav), int'(rxb_ready[p]));
    end
    txb_room = 4'hF; rxb_ready = 4'hF;
    @(negedge clk); tx_addr = 5'h1F; rx_addr = 5'h00;
    @(negedge clk);
    chk(tx_clav === 1'b0, "R2 tx unmatched floats", int'(tx_clav), 0);
    chk(rx_clav === 1'b0, "R2 rx unmatched floats", int'(rx_clav), 0);
    rxb_ready = 0; rx_addr = 5'h1F;
  endtask

  task automatic t_tx_basic;
    clr_cap(2);
    tx_cell(2, 27, -1, 12);
    chk(cap_n == 27, "R3 beat count", cap_n, 27);
    chk(data_miss(2) == 0, "R3 beat data", data_miss(2), 0);
    chk(cap_last == 1, "R3 last marker", cap_last, 1);
    chk(cap_badport == 0, "R4 port held through pause", cap_badport, 0);
  endtask

  task automatic t_par_off;
    par_irq_en = 0; clr_cap(1);
    tx_cell(1, 27, 7, -1);
    chk(tx_par_irq === 4'b0000, "R6 no flag when disabled", int'(tx_par_irq), 0);
    chk(cap_n == 27 && cap_last == 1, "R6 cell kept", cap_n, 27);
  endtask

  task automatic t_par_on;
    par_irq_en = 1; clr_cap(3);
    tx_cell(3, 27, 3, -1);
    chk(tx_par_irq === 4'b1000, "R5 flag on port 3", int'(tx_par_irq), 8);
    chk(cap_n == 27 && data_miss(3) == 0, "R5 cell kept", cap_n, 27);
  endtask

  task automatic t_runt;
    clr_cap(0);
    tx_cell(0, 10, -1, -1);
    chk(cap_abort == 0, "R7 no abort before restart", cap_abort, 0);
    tx_cell(0, 27, -1, -1);
    chk(cap_abort == 1, "R7 abort pulse", cap_abort, 1);
    chk(tx_runt === 4'b0001, "R7 runt flag port 0", int'(tx_runt), 1);
    chk(cap_n == 37 && cap_last == 1, "R7 restart completes", cap_n, 37);
    chk(cap_badport == 0 && data_miss(0) == 0, "R7 restarted data", data_miss(0), 0);
  endtask

  task automatic t_idle_words;
    clr_cap(0);
    @(negedge clk); tx_addr = 5'h1F; tx_en_n = 1;
    @(negedge clk); tx_en_n = 0;
    for (int i = 0; i < 5; i++) begin
      tx_soc = (i == 2); tx_data = twd(0, i); tx_par = ~^twd(0, i);
      @(negedge clk);
    end
    tx_en_n = 1; tx_soc = 0;
    repeat (2) @(negedge clk);
    chk(cap_n == 0, "R11 stray words ignored", cap_n, 0);
  endtask

  task automatic t_rx;
    int bad = 0, socbad = 0, parbad = 0;
    rxb_ready = 4'b0010;
    @(negedge clk); rx_addr = paddr(1); rx_en_n = 1;
    @(negedge clk); rx_en_n = 0; rx_addr = paddr(2);
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      if (rx_data !== rwd(1, i)) bad++;
      if (rx_soc !== (i == 0)) socbad++;
      if (^{rx_par, rx_data} !== 1'b1) parbad++;
      if (i == 26)
        chk(rxr_pop === 1'b1 && rxr_pop_port === 2'd1, "R8 pop with last word", int'(rxr_pop), 1);
      else if (rxr_pop !== 1'b0) bad++;
      if (i == 12) begin
        rx_en_n = 1;
        @(negedge clk);
        chk(rx_data === rwd(1, 12), "R8 hold while paused", int'(rx_data), int'(rwd(1, 12)));
        rx_en_n = 0;
      end
    end
    rx_en_n = 1; rxb_ready = 0; rx_addr = 5'h1F;
    chk(bad == 0, "R8 rx word sequence", bad, 0);
    chk(socbad == 0, "R8 rx soc on first only", socbad, 0);
    chk(parbad == 0, "R9 rx odd parity", parbad, 0);
  endtask

  task automatic t_led_single;
    repeat (300) @(negedge osc_clk);
    for (int p = 0; p < 4; p++) led_low[p] = 0;
    clr_cap(1);
    tx_cell(1, 27, -1, -1);
    repeat (300) @(negedge osc_clk);
    chk(led_low[1] == 223, "R10 single pulse length", led_low[1], 223);
    chk(led_low[0] + led_low[2] + led_low[3] == 0, "R10 other ports dark", led_low[0], 0);
  endtask

  task automatic t_led_restart;
    for (int p = 0; p < 4; p++) led_low[p] = 0;
    clr_cap(3);
    tx_cell(3, 27, -1, -1);
    repeat (69) @(negedge clk);
    clr_cap(3);
    tx_cell(3, 27, -1, -1);
    repeat (400) @(negedge osc_clk);
    chk(led_low[3] >= 289 && led_low[3] <= 299, "R10 restarted pulse", led_low[3], 294);
  endtask

  initial begin
    repeat (8) @(posedge clk);
    @(negedge clk); rst = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_poll();
    txb_room = 4'hF;
    t_tx_basic();
    t_par_off();
    t_par_on();
    t_runt();
    t_idle_words();
    t_rx();
    t_led_single();
    t_led_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule